// File: doc/BRIEF.md
# Pacing Artifact Detector

This block watches a stream of 12-bit unsigned ECG samples and flags the short, steep spikes that an implanted pacemaker leaves in the recording. Each accepted sample goes through a first-order recursive high-pass filter. The filter's zero at DC removes the mid-scale bias code and flattens the slower QRS complex. The filtered value is then compared against a threshold that is symmetric about zero. This makes the detector independent of any error in the bias source.

At a typical rate of 32 kSPS, a pacing spike is 16 to 64 samples long. The detector reports a single-sample detect pulse and a polarity flag. It also publishes every filtered sample as a signed value for downstream use. A refractory count stops one spike from being reported many times. Threshold and refractory length are captured together with each sample, so either can be changed between samples.

Top module: `pace_detect`

## Requirements
- R1: The filter keeps a signed accumulator with 8 fractional bits. For each accepted sample it computes acc = acc − floor(acc/128) + 256·d, where d = x[n] − x[n−1]. The published o_filt is floor(acc/256), as 13-bit two's complement.
- R2: After reset the accumulator is zero and the first accepted sample serves as its own predecessor. The first filtered output is therefore 0 whatever the code, and a constant input stays at 0.
- R3: A sample accepted on a clock edge with s_valid high produces o_valid high for exactly one cycle, two edges later. o_valid is low after the first of those edges.
- R4: When o_valid is high and o_filt > thr, with thr read as unsigned, o_detect is 1 and o_pos is 1, unless the refractory window of R6 blocks it.
- R5: When o_valid is high and o_filt < −thr, o_detect is 1 and o_pos is 0, unless the refractory window of R6 blocks it.
- R6: After a detection, the next refr_len output samples cannot detect. refr_len = 0 allows detections on consecutive samples.
- R7: o_pos keeps its value between detections. o_filt keeps its value while o_valid is low.
- R8: thr and refr_len are captured with each accepted sample and apply to that sample's output. A change takes effect from the next accepted sample.
- R9: During and just after reset, o_valid, o_filt, o_detect and o_pos are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample strobe |
| s_data | input | 12 | Unsigned ADC code |
| thr | input | 12 | Detection threshold, in filtered LSBs |
| refr_len | input | 8 | Refractory length in samples (nominally 64) |
| o_valid | output | 1 | Filtered sample strobe |
| o_filt | output | 13 | Signed filtered sample |
| o_detect | output | 1 | Detection pulse |
| o_pos | output | 1 | Polarity of the last detection, 1 = positive |

## Verification
The filter is driven with several input patterns, and each one separates a different possible fault:
- A flat baseline at mid-scale and at an offset first code separates correct DC removal from a wrong starting predecessor.
- Narrow positive and negative steps tell the two comparator sides apart.
- A wide, large step held with a short refractory length makes a decaying tail cross the threshold again, which exposes an off-by-one in the blocking count.
- A zero refractory length with a large jump shows back-to-back detections.
- The all-ones threshold must never fire.
- Threshold changes between segments show whether a new value is applied one sample early or late.

Every filtered value is compared against a fixed-point reference, so a wrong coefficient or rounding shows up as a value mismatch.

// File: rtl/pd_pkg.sv
package pd_pkg;
   localparam int PD_SAMPLE_W = 12;
   localparam int PD_FRAC_W   = 8;
   localparam int PD_SHIFT    = 7;
   localparam int PD_REFR_W   = 8;

   typedef enum logic {
      PD_NEG = 1'b0,
      PD_POS = 1'b1
   } pd_pol_e;
endpackage

// File: rtl/pd_diff_stage.sv
module pd_diff_stage #(
   parameter int SAMPLE_W    = 12,
   parameter int THR_W       = 12,
   parameter int REFR_W      = 8,
   parameter bit PRIME_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [SAMPLE_W-1:0]   in_x,
   input  logic [THR_W-1:0]      in_thr,
   input  logic [REFR_W-1:0]     in_refr,
   output logic                  d_valid,
   output logic signed [SAMPLE_W:0] d_diff,
   output logic [THR_W-1:0]      d_thr,
   output logic [REFR_W-1:0]     d_refr
);
   localparam logic [SAMPLE_W-1:0] MID_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

   logic [SAMPLE_W-1:0] x_prev;
   logic                primed;
   logic [SAMPLE_W-1:0] base;
   logic signed [SAMPLE_W:0] diff_c;

   generate
      if (PRIME_FIRST) begin : g_prime
         // first sample after reset is its own predecessor
         assign base = primed ? x_prev : in_x;
      end else begin : g_mid
         assign base = x_prev;
      end
   endgenerate

   assign diff_c = $signed({1'b0, in_x}) - $signed({1'b0, base});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_prev  <= MID_CODE;
         primed  <= 1'b0;
         d_valid <= 1'b0;
         d_diff  <= '0;
         d_thr   <= '0;
         d_refr  <= '0;
      end else begin
         d_valid <= in_valid;
         if (in_valid) begin
            x_prev <= in_x;
            primed <= 1'b1;
            d_diff <= diff_c;
            d_thr  <= in_thr;
            d_refr <= in_refr;
         end
      end
   end

   AST_STAGE1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> d_valid); // R3
endmodule

// File: rtl/pd_dcblock.sv
module pd_dcblock #(
   parameter int IN_W     = 13,
   parameter int INT_W    = 13,
   parameter int FRAC_W   = 8,
   parameter int SHIFT    = 7,
   parameter bit SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    d_valid,
   input  logic signed [IN_W-1:0]  d_diff,
   output logic signed [INT_W-1:0] y_new,
   output logic signed [INT_W-1:0] y_int,
   output logic                    y_valid
);
   localparam int ACC_W = INT_W + FRAC_W;
   localparam int EXT_W = ACC_W + 2;
   localparam logic signed [EXT_W-1:0] ACC_MAX =
      {{(EXT_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
   localparam logic signed [EXT_W-1:0] ACC_MIN =
      {{(EXT_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] acc_lim;
   logic signed [ACC_W-1:0] acc_new;
   logic signed [EXT_W-1:0] acc_ext;
   logic signed [EXT_W-1:0] diff_ext;
   logic signed [EXT_W-1:0] sum;

   assign acc_ext  = {{(EXT_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
   assign diff_ext = {{(EXT_W-IN_W){d_diff[IN_W-1]}}, d_diff};
   // pole at 1 - 2^-SHIFT, realised as shift-and-subtract
   assign sum = acc_ext - (acc_ext >>> SHIFT) + (diff_ext <<< FRAC_W);

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (sum > ACC_MAX)      acc_lim = ACC_MAX[ACC_W-1:0];
            else if (sum < ACC_MIN) acc_lim = ACC_MIN[ACC_W-1:0];
            else                    acc_lim = sum[ACC_W-1:0];
         end
      end else begin : g_wrap
         assign acc_lim = sum[ACC_W-1:0];
      end
   endgenerate

   assign acc_new = d_valid ? acc_lim : acc_q;
   assign y_new   = acc_new[ACC_W-1:FRAC_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         y_int   <= '0;
         y_valid <= 1'b0;
      end else begin
         y_valid <= d_valid;
         acc_q   <= acc_new;
         if (d_valid) y_int <= y_new;
      end
   end

   // with no new difference a non-negative state may only decay
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && d_diff == '0 && acc_q >= 0) |=> (acc_q <= $past(acc_q) && acc_q >= 0)); // R1
endmodule

// File: rtl/pd_threshold.sv
module pd_threshold #(
   parameter int INT_W  = 13,
   parameter int THR_W  = 12,
   parameter int REFR_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chk_valid,
   input  logic signed [INT_W-1:0] y_new,
   input  logic [THR_W-1:0]        thr,
   input  logic [REFR_W-1:0]       refr,
   output logic                    det,
   output logic                    pos
);
   import pd_pkg::*;

   localparam int CMP_W = ((INT_W > THR_W + 1) ? INT_W : THR_W + 1) + 1;
   localparam logic [REFR_W-1:0] ONE = {{(REFR_W-1){1'b0}}, 1'b1};

   logic signed [CMP_W-1:0] y_e;
   logic signed [CMP_W-1:0] thr_e;
   logic                    over;
   logic                    under;
   logic [REFR_W-1:0]       cnt;

   assign y_e   = {{(CMP_W-INT_W){y_new[INT_W-1]}}, y_new};
   assign thr_e = $signed({{(CMP_W-THR_W){1'b0}}, thr});
   assign over  = y_e > thr_e;
   assign under = y_e < -thr_e;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         det <= 1'b0;
         pos <= PD_NEG;
         cnt <= '0;
      end else begin
         det <= 1'b0;
         if (chk_valid) begin
            if (cnt != '0) begin
               cnt <= cnt - ONE;
            end else if (over || under) begin
               det <= 1'b1;
               pos <= over ? PD_POS : PD_NEG;
               cnt <= refr;
            end
         end
      end
   end

   AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !det |-> $stable(pos)); // R7
endmodule

// File: rtl/pace_detect.sv
module pace_detect #(
   parameter int SAMPLE_W    = pd_pkg::PD_SAMPLE_W,
   parameter int FRAC_W      = pd_pkg::PD_FRAC_W,
   parameter int SHIFT       = pd_pkg::PD_SHIFT,
   parameter int REFR_W      = pd_pkg::PD_REFR_W,
   parameter bit SATURATE    = 1'b1,
   parameter bit PRIME_FIRST = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  s_valid,
   input  logic [SAMPLE_W-1:0]   s_data,
   input  logic [SAMPLE_W-1:0]   thr,
   input  logic [REFR_W-1:0]     refr_len,
   output logic                  o_valid,
   output logic [SAMPLE_W:0]     o_filt,
   output logic                  o_detect,
   output logic                  o_pos
);
   localparam int DIFF_W = SAMPLE_W + 1;
   localparam int INT_W  = SAMPLE_W + 1;

   generate
      if (SHIFT < 1 || SHIFT > FRAC_W) begin : g_bad_shift
         $error("pace_detect: SHIFT must lie in 1..FRAC_W");
      end
      if (FRAC_W < 8) begin : g_bad_frac
         $error("pace_detect: FRAC_W must be at least 8");
      end
      if (REFR_W < 1) begin : g_bad_refr
         $error("pace_detect: REFR_W must be positive");
      end
   endgenerate

   logic                     d_valid;
   logic signed [DIFF_W-1:0] d_diff;
   logic [SAMPLE_W-1:0]      d_thr;
   logic [REFR_W-1:0]        d_refr;
   logic signed [INT_W-1:0]  y_new;
   logic signed [INT_W-1:0]  y_int;

   pd_diff_stage #(
      .SAMPLE_W(SAMPLE_W), .THR_W(SAMPLE_W), .REFR_W(REFR_W), .PRIME_FIRST(PRIME_FIRST)
   ) u_diff (
      .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_x(s_data),
      .in_thr(thr), .in_refr(refr_len),
      .d_valid(d_valid), .d_diff(d_diff), .d_thr(d_thr), .d_refr(d_refr)
   );

   pd_dcblock #(
      .IN_W(DIFF_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .SHIFT(SHIFT), .SATURATE(SATURATE)
   ) u_filt (
      .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_diff(d_diff),
      .y_new(y_new), .y_int(y_int), .y_valid(o_valid)
   );

   pd_threshold #(
      .INT_W(INT_W), .THR_W(SAMPLE_W), .REFR_W(REFR_W)
   ) u_cmp (
      .clk(clk), .rst_n(rst_n), .chk_valid(d_valid), .y_new(y_new),
      .thr(d_thr), .refr(d_refr), .det(o_detect), .pos(o_pos)
   );

   assign o_filt = y_int;

   AST_PIPE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid |=> ##1 o_valid); // R3
   AST_DET_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      o_detect |-> o_valid); // R4
   AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !o_valid |-> $stable(o_filt)); // R7
endmodule

// File: tb/pace_detect_bench.sv
`timescale 1ns/1ps
module pace_detect_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid = 1'b0;
   logic [11:0] s_data = '0;
   logic [11:0] thr = '0;
   logic [7:0]  refr_len = '0;
   logic        o_valid;
   logic [12:0] o_filt;
   logic        o_detect;
   logic        o_pos;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pace_detect u_pace_detect (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
      .thr(thr), .refr_len(refr_len), .o_valid(o_valid), .o_filt(o_filt),
      .o_detect(o_detect), .o_pos(o_pos)
   );

   typedef struct packed {
      logic [11:0] x;
      logic [7:0]  n;
      logic [11:0] th;
      logic [7:0]  rf;
   } seg_t;

   // stimulus segments; expected outputs come from the reference model below
   localparam seg_t SEGS [12] = '{
      '{12'd2048, 8'd10,  12'd30,   8'd64},
      '{12'd2088, 8'd20,  12'd30,   8'd64},
      '{12'd2048, 8'd80,  12'd30,   8'd64},
      '{12'd1990, 8'd16,  12'd30,   8'd64},
      '{12'd2048, 8'd80,  12'd30,   8'd64},
      '{12'd2100, 8'd64,  12'd30,   8'd8},
      '{12'd2048, 8'd100, 12'd30,   8'd8},
      '{12'd2070, 8'd30,  12'd4095, 8'd8},
      '{12'd2048, 8'd40,  12'd20,   8'd0},
      '{12'd3000, 8'd20,  12'd20,   8'd0},
      '{12'd2048, 8'd40,  12'd20,   8'd0},
      '{12'd1000, 8'd20,  12'd20,   8'd3}
   };

   // reference model state
   longint m_prev, m_acc, m_y;
   bit     m_primed;
   int     m_cnt;
   bit     m_det, m_pos;

   task automatic model_reset();
      m_prev = 0; m_acc = 0; m_y = 0; m_primed = 0;
      m_cnt = 0; m_det = 0; m_pos = 0;
   endtask

   task automatic model_step(input int x, input int th, input int rf);
      longint d;
      d = m_primed ? (longint'(x) - m_prev) : 0;
      m_prev = x;
      m_primed = 1;
      m_acc = m_acc - (m_acc >>> 7) + d * 256;
      if (m_acc > 1048575) m_acc = 1048575;
      if (m_acc < -1048576) m_acc = -1048576;
      m_y = m_acc >>> 8;
      m_det = 0;
      if (m_cnt != 0) m_cnt--;
      else if (m_y > th) begin m_det = 1; m_pos = 1; m_cnt = rf; end
      else if (m_y < -th) begin m_det = 1; m_pos = 0; m_cnt = rf; end
   endtask

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic put(input int x, input int th, input int rf, input string ftag);
      longint got;
      @(negedge clk);
      s_data = 12'(x); thr = 12'(th); refr_len = 8'(rf); s_valid = 1'b1;
      model_step(x, th, rf);
      @(negedge clk);
      s_valid = 1'b0;
      check(o_valid == 1'b0, "R3 early valid", longint'(o_valid), 0);
      @(negedge clk);
      got = longint'($signed(o_filt));
      check(o_valid == 1'b1, "R3 valid", longint'(o_valid), 1);
      check(got == m_y, ftag, got, m_y);
      check(o_detect == m_det, "R4 R5 R6 detect", longint'(o_detect), longint'(m_det));
      check(o_pos == m_pos, "R4 R5 R7 polarity", longint'(o_pos), longint'(m_pos));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      s_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(o_valid == 0 && o_filt == '0 && o_detect == 0 && o_pos == 0,
            "R9 reset state", longint'({o_valid, o_filt, o_detect, o_pos}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(o_valid == 0 && o_filt == '0 && o_detect == 0 && o_pos == 0,
            "R9 after release", longint'({o_valid, o_filt, o_detect, o_pos}), 0);
      model_reset();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      do_reset();

      // R2: first sample far from mid-scale still gives zero output
      put(3000, 30, 64, "R2 first sample");
      put(3000, 30, 64, "R2 constant input");
      put(3000, 30, 64, "R2 constant input");

      // walk the stimulus table; thr and refr_len change between segments (R8)
      for (int s = 0; s < 12; s++) begin
         for (int k = 0; k < int'(SEGS[s].n); k++) begin
            put(int'(SEGS[s].x), int'(SEGS[s].th), int'(SEGS[s].rf), "R1 filter value");
         end
      end

      // R7: output held while idle
      begin
         logic [12:0] held;
         held = o_filt;
         repeat (6) @(negedge clk);
         check(o_filt == held && o_valid == 0, "R7 idle hold",
               longint'(o_filt), longint'(held));
      end

      // R8: threshold raised on the very sample that would have fired
      do_reset();
      put(2048, 10, 0, "R8 baseline");
      put(2100, 4095, 0, "R8 new thr applies");
      check(o_detect == 0, "R8 high thr blocks", longint'(o_detect), 0);
      put(2200, 10, 0, "R8 thr lowered");
      check(o_detect == 1 && o_pos == 1, "R4 R8 detect after lower",
            longint'({o_detect, o_pos}), 3);

      // R6: refractory of 2 samples on a sustained large step
      do_reset();
      put(2048, 5, 2, "R6 base");
      put(2600, 5, 2, "R6 step");
      check(o_detect == 1, "R6 first hit", longint'(o_detect), 1);
      put(2600, 5, 2, "R6 blocked1");
      check(o_detect == 0, "R6 blocked", longint'(o_detect), 0);
      put(2600, 5, 2, "R6 blocked2");
      check(o_detect == 0, "R6 blocked", longint'(o_detect), 0);
      put(2600, 5, 2, "R6 released");
      check(o_detect == 1, "R6 released", longint'(o_detect), 1);

      // R5: negative spike after reset with zero refractory
      do_reset();
      put(2048, 15, 0, "R5 base");
      put(1900, 15, 0, "R5 drop");
      check(o_detect == 1 && o_pos == 0, "R5 negative hit",
            longint'({o_detect, o_pos}), 2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule